// File: doc/BRIEF.md
# Paged Address Translator with Access Permissions

This block sits between an execution unit and the physical address pins. It turns every 32-bit virtual address it receives into a physical address by replacing the page number, using a small fully associative set of mapping entries. The page size is 4 KB, so the low 12 bits of the address pass through unchanged. Each entry also holds read, write and execute rights and a flag that opens the page to user mode. Every access is checked against these rights, the access kind and the current privilege mode. An access that finds no entry, or that breaks the rights, gets no physical address. It is refused with a fault and a 2-bit cause code.

Privileged software loads, rewrites and invalidates entries through a configuration port. After that, translation runs on every request without any per-access control. A global enable input turns translation off. With translation off, virtual addresses go straight through as physical addresses and no check is made. The lookup itself is combinational. The result is registered, so each request gets its response exactly one cycle later, marked by a valid strobe. The physical width is a parameter and may differ from the 32-bit virtual width.

Top module: `page_xlate`

## Requirements
- R1: A request with `req_valid` high at a rising edge produces `rsp_valid` high during the following cycle. With `req_valid` low, `rsp_valid` is low in the following cycle, and `rsp_fault`, `rsp_cause` and `rsp_paddr` are zero.
- R2: On a successful translation, `rsp_paddr` is the entry's physical page number followed by the low 12 bits of the virtual address. For example, virtual page 0xb7001 mapped to physical page 0x2 turns 0xb7001008 into 0x2008.
- R3: When translation is enabled and no valid entry holds the request's virtual page number (bits 31:12), the response faults with cause 1.
- R4: In user mode (`req_priv` = 0), an access that hits an entry whose user flag is 0 faults with cause 2. This privilege check is made before the access-kind check.
- R5: The access kind is encoded 0 = data read, 1 = data write, 2 = instruction fetch and 3 = reserved. An access whose kind lacks the matching right in the hit entry faults with cause 3, and kind 3 always faults with cause 3. A page with no rights is therefore refused in both modes.
- R6: In privileged mode (`req_priv` = 1), an entry is usable whatever its user flag is. Only its rights are checked.
- R7: When several valid entries hold the same virtual page number, the lowest-index entry supplies the translation.
- R8: With `xlate_en` low, `rsp_paddr` is the virtual address, zero-extended or truncated to the physical width, and no fault is raised, whatever entries exist.
- R9: A configuration write with `cfg_we` = 1 and `cfg_priv` = 1 loads the entry at `cfg_idx` with the given page numbers, rights and valid bit. Writing valid = 0 invalidates the entry. Lookups see the new contents from the next cycle.
- R10: A configuration write with `cfg_priv` = 0 is ignored, and the entries keep their contents.
- R11: A faulted response has `rsp_fault` = 1, a nonzero `rsp_cause` and `rsp_paddr` = 0. A successful response has `rsp_fault` = 0 and `rsp_cause` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; clears all entries and the response |
| xlate_en | input | 1 | 1 = translate and check, 0 = pass addresses through |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch, 3 reserved |
| req_priv | input | 1 | 1 = privileged mode, 0 = user mode |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_paddr | output | PA_W | Physical address, zero on a fault |
| rsp_fault | output | 1 | Access refused |
| rsp_cause | output | 2 | Fault cause: 0 none, 1 no mapping, 2 privilege, 3 access kind |
| cfg_we | input | 1 | Entry write strobe |
| cfg_priv | input | 1 | Mode of the writer; the write is taken only when 1 |
| cfg_idx | input | IDX_W | Entry index to write |
| cfg_valid | input | 1 | Valid bit to store (0 invalidates) |
| cfg_vpn | input | 20 | Virtual page number to store |
| cfg_ppn | input | PA_W-12 | Physical page number to store |
| cfg_rd | input | 1 | Read right |
| cfg_wr | input | 1 | Write right |
| cfg_ex | input | 1 | Execute right |
| cfg_usr | input | 1 | User-mode access allowed |

## Verification
The hardest case to reach from the ports is two valid entries that both hold the same virtual page number. Software normally never builds this, yet the lowest-index rule decides the outcome. The bench loads such a duplicate pair on purpose, with different physical pages, and checks that the lower slot wins. It then invalidates the lower slot and checks that the higher one takes over, and invalidates that one too and checks for a miss. A user-mode attempt to overwrite an entry is shown to be ignored by translating through that entry again afterwards. The ordering of the privilege check before the access-kind check is shown with a user access to a privileged-only page whose rights would also refuse the access kind.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  localparam int VA_W     = 32;
  localparam int OFF_W    = 12;
  localparam int VPN_W    = VA_W - OFF_W;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } access_e;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_MISS = 2'd1,
    CAUSE_PRIV = 2'd2,
    CAUSE_PERM = 2'd3
  } cause_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic ex;
    logic usr;
  } perm_t;

endpackage

// File: rtl/xlate_table.sv
module xlate_table
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PPN_W   = 22,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic             cfg_priv,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [VPN_W-1:0] cfg_vpn,
  input  logic [PPN_W-1:0] cfg_ppn,
  input  perm_t            cfg_perm,
  output logic             ent_valid [ENTRIES],
  output logic [VPN_W-1:0] ent_vpn   [ENTRIES],
  output logic [PPN_W-1:0] ent_ppn   [ENTRIES],
  output perm_t            ent_perm  [ENTRIES]
);

  // Writes count only from privileged software and to an existing slot.
  logic take_write;
  assign take_write = cfg_we && cfg_priv && (int'(cfg_idx) < ENTRIES);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    logic hit_slot;
    assign hit_slot = take_write && (int'(cfg_idx) == g);

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[g] <= 1'b0;
        ent_vpn[g]   <= '0;
        ent_ppn[g]   <= '0;
        ent_perm[g]  <= '0;
      end else if (hit_slot) begin
        ent_valid[g] <= cfg_valid;
        ent_vpn[g]   <= cfg_vpn;
        ent_ppn[g]   <= cfg_ppn;
        ent_perm[g]  <= cfg_perm;
      end
    end

    // R10: a user-mode write leaves every slot as it was
    assert_user_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && !cfg_priv) |=> ($stable(ent_valid[g]) && $stable(ent_vpn[g]) &&
                                 $stable(ent_ppn[g])   && $stable(ent_perm[g])));

    // R9: a privileged write lands in the addressed slot
    assert_cfg_write_lands_R9: assert property (@(posedge clk) disable iff (rst)
      (cfg_we && cfg_priv && int'(cfg_idx) == g) |=>
        (ent_valid[g] == $past(cfg_valid) && ent_vpn[g] == $past(cfg_vpn) &&
         ent_ppn[g] == $past(cfg_ppn)));
  end

endmodule

// File: rtl/xlate_lookup.sv
module xlate_lookup
  import xlate_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PPN_W   = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [VPN_W-1:0] look_vpn,
  input  logic             ent_valid [ENTRIES],
  input  logic [VPN_W-1:0] ent_vpn   [ENTRIES],
  input  logic [PPN_W-1:0] ent_ppn   [ENTRIES],
  input  perm_t            ent_perm  [ENTRIES],
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output perm_t            hit_perm
);

  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] grant;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = ent_valid[g] && (ent_vpn[g] == look_vpn);
  end

  // Lowest index wins: walk from the top so the lowest match is written last.
  always_comb begin
    grant    = '0;
    hit_ppn  = '0;
    hit_perm = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        hit_ppn  = ent_ppn[i];
        hit_perm = ent_perm[i];
      end
    end
  end

  assign hit = |grant;

  // R7: at most one entry is chosen, and it is one that matched
  assert_single_grant_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && ((grant & ~match) == '0));

  // R3: any match must give a hit
  assert_match_hits_R3: assert property (@(posedge clk) disable iff (rst)
    (match != '0) |-> hit);

endmodule

// File: rtl/xlate_check.sv
module xlate_check
  import xlate_pkg::*;
(
  input  logic     hit,
  input  perm_t    perm,
  input  logic [1:0] kind,
  input  logic     priv,
  output cause_e   cause
);

  logic kind_ok;

  always_comb begin
    unique case (access_e'(kind))
      ACC_LOAD:  kind_ok = perm.rd;
      ACC_STORE: kind_ok = perm.wr;
      ACC_FETCH: kind_ok = perm.ex;
      default:   kind_ok = 1'b0;
    endcase
  end

  // Order: mapping, then mode, then access kind.
  always_comb begin
    if (!hit)                    cause = CAUSE_MISS;
    else if (!priv && !perm.usr) cause = CAUSE_PRIV;
    else if (!kind_ok)           cause = CAUSE_PERM;
    else                         cause = CAUSE_NONE;
  end

endmodule

// File: rtl/page_xlate.sv
module page_xlate
  import xlate_pkg::*;
#(
  parameter int PA_W    = 34,
  parameter int ENTRIES = 8,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xlate_en,
  input  logic             req_valid,
  input  logic [31:0]      req_vaddr,
  input  logic [1:0]       req_kind,
  input  logic             req_priv,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  input  logic             cfg_we,
  input  logic             cfg_priv,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic             cfg_valid,
  input  logic [19:0]      cfg_vpn,
  input  logic [PPN_W-1:0] cfg_ppn,
  input  logic             cfg_rd,
  input  logic             cfg_wr,
  input  logic             cfg_ex,
  input  logic             cfg_usr
);

  logic             ent_valid [ENTRIES];
  logic [VPN_W-1:0] ent_vpn   [ENTRIES];
  logic [PPN_W-1:0] ent_ppn   [ENTRIES];
  perm_t            ent_perm  [ENTRIES];
  perm_t            cfg_perm;

  logic             hit;
  logic [PPN_W-1:0] hit_ppn;
  perm_t            hit_perm;
  cause_e           chk_cause;

  assign cfg_perm = '{rd: cfg_rd, wr: cfg_wr, ex: cfg_ex, usr: cfg_usr};

  xlate_table #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) i_table (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_priv  (cfg_priv),
    .cfg_idx   (cfg_idx),
    .cfg_valid (cfg_valid),
    .cfg_vpn   (cfg_vpn),
    .cfg_ppn   (cfg_ppn),
    .cfg_perm  (cfg_perm),
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_ppn   (ent_ppn),
    .ent_perm  (ent_perm)
  );

  xlate_lookup #(.ENTRIES(ENTRIES), .PPN_W(PPN_W)) i_lookup (
    .clk       (clk),
    .rst       (rst),
    .look_vpn  (req_vaddr[VA_W-1:OFF_W]),
    .ent_valid (ent_valid),
    .ent_vpn   (ent_vpn),
    .ent_ppn   (ent_ppn),
    .ent_perm  (ent_perm),
    .hit       (hit),
    .hit_ppn   (hit_ppn),
    .hit_perm  (hit_perm)
  );

  xlate_check i_check (
    .hit   (hit),
    .perm  (hit_perm),
    .kind  (req_kind),
    .priv  (req_priv),
    .cause (chk_cause)
  );

  // Next-state of the response register.
  logic [PA_W-1:0] nxt_paddr;
  logic [1:0]      nxt_cause;

  always_comb begin
    nxt_paddr = '0;
    nxt_cause = CAUSE_NONE;
    if (req_valid) begin
      if (!xlate_en) begin
        nxt_paddr = PA_W'(req_vaddr);
      end else begin
        nxt_cause = chk_cause;
        if (chk_cause == CAUSE_NONE)
          nxt_paddr = {hit_ppn, req_vaddr[OFF_W-1:0]};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'd0;
    end else begin
      rsp_valid <= req_valid;
      rsp_paddr <= nxt_paddr;
      rsp_fault <= (nxt_cause != CAUSE_NONE);
      rsp_cause <= nxt_cause;
    end
  end

  // R1: fixed one-cycle latency
  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!rsp_valid && !rsp_fault && rsp_paddr == '0));

  // R2: page offset survives translation
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && xlate_en) |=>
      (rsp_fault || rsp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

  // R8: bypass never faults and copies the address
  assert_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !xlate_en) |=>
      (!rsp_fault && rsp_paddr == PA_W'($past(req_vaddr))));

  // R11: fault and cause agree, refused access carries no address
  assert_fault_shape_R11: assert property (@(posedge clk) disable iff (rst)
    (rsp_fault == (rsp_cause != 2'd0)) && (!rsp_fault || rsp_paddr == '0));

endmodule

// File: tb/test_page_xlate.sv
module test_page_xlate;

  localparam int CLK_PERIOD = 10;
  localparam int PA_W       = 34;
  localparam int PPN_W      = PA_W - 12;
  localparam int ENTRIES    = 8;
  localparam int IDX_W      = 3;

  logic             clk = 1'b0;
  logic             rst;
  logic             xlate_en;
  logic             req_valid;
  logic [31:0]      req_vaddr;
  logic [1:0]       req_kind;
  logic             req_priv;
  logic             rsp_valid;
  logic [PA_W-1:0]  rsp_paddr;
  logic             rsp_fault;
  logic [1:0]       rsp_cause;
  logic             cfg_we, cfg_priv, cfg_valid;
  logic [IDX_W-1:0] cfg_idx;
  logic [19:0]      cfg_vpn;
  logic [PPN_W-1:0] cfg_ppn;
  logic             cfg_rd, cfg_wr, cfg_ex, cfg_usr;

  int n_checks = 0;
  int n_errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  page_xlate #(.PA_W(PA_W), .ENTRIES(ENTRIES)) i_page_xlate (
    .clk, .rst, .xlate_en, .req_valid, .req_vaddr, .req_kind, .req_priv,
    .rsp_valid, .rsp_paddr, .rsp_fault, .rsp_cause,
    .cfg_we, .cfg_priv, .cfg_idx, .cfg_valid, .cfg_vpn, .cfg_ppn,
    .cfg_rd, .cfg_wr, .cfg_ex, .cfg_usr
  );

  // kind: 0 read, 1 write, 2 fetch, 3 reserved; cause: 0 ok, 1 miss, 2 priv, 3 kind
  typedef struct packed {
    logic [31:0]     va;
    logic [1:0]      kind;
    logic            priv;
    logic [1:0]      cause;
    logic [PA_W-1:0] pa;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{32'hb7001008, 2'd0, 1'b0, 2'd0, 34'h000002008},  // R2 example mapping
    '{32'hb7001ffc, 2'd1, 1'b0, 2'd0, 34'h000002ffc},  // R2 write, top offset
    '{32'hb7001010, 2'd2, 1'b0, 2'd3, 34'h0},          // R5 fetch without X
    '{32'h00400abc, 2'd2, 1'b0, 2'd0, 34'h030000abc},  // R2 fetch from code page
    '{32'h00400000, 2'd1, 1'b0, 2'd3, 34'h0},          // R5 write to code page
    '{32'hc0000123, 2'd1, 1'b0, 2'd2, 34'h0},          // R4 user on kernel page (W also absent)
    '{32'hc0000123, 2'd0, 1'b1, 2'd0, 34'h000100123},  // R6 privileged on kernel page
    '{32'hc0000004, 2'd2, 1'b1, 2'd3, 34'h0},          // R5 privileged fetch without X
    '{32'h00500000, 2'd0, 1'b1, 2'd3, 34'h0},          // R5 page with no rights
    '{32'h12345678, 2'd0, 1'b1, 2'd1, 34'h0},          // R3 miss
    '{32'h00600044, 2'd1, 1'b0, 2'd0, 34'h000011044},  // R7 duplicate, slot 4 wins
    '{32'hb7001008, 2'd3, 1'b1, 2'd3, 34'h0}           // R5 reserved kind
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [1:0] c);
    case (c)
      2'd1:    return "R3 miss";
      2'd2:    return "R4 privilege";
      2'd3:    return "R5 access kind";
      default: return "R2 translate";
    endcase
  endfunction

  task automatic cfg_write(input logic pr, input int idx, input logic v,
                           input logic [19:0] vpn, input logic [PPN_W-1:0] ppn,
                           input logic r, input logic w, input logic x, input logic u);
    @(negedge clk);
    cfg_we = 1'b1; cfg_priv = pr; cfg_idx = IDX_W'(idx); cfg_valid = v;
    cfg_vpn = vpn; cfg_ppn = ppn; cfg_rd = r; cfg_wr = w; cfg_ex = x; cfg_usr = u;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive at the falling edge, sample 1 time unit after the next rising edge.
  task automatic access(input logic [31:0] va, input logic [1:0] kind, input logic pr);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = kind; req_priv = pr;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    rst = 1'b1; xlate_en = 1'b1; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    req_priv = 1'b0; cfg_we = 1'b0; cfg_priv = 1'b0; cfg_idx = '0; cfg_valid = 1'b0;
    cfg_vpn = '0; cfg_ppn = '0; cfg_rd = 1'b0; cfg_wr = 1'b0; cfg_ex = 1'b0; cfg_usr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R11 reset fault", 64'(rsp_fault), 64'd0);
    @(negedge clk);
    rst = 1'b0;

    // Empty table: a request misses.
    access(32'hb7001008, 2'd0, 1'b1);
    chk("R3 empty table cause", 64'(rsp_cause), 64'd1);
    @(negedge clk); req_valid = 1'b0;

    // Fill the table.
    cfg_write(1'b1, 0, 1'b1, 20'hb7001, 22'h2,     1, 1, 0, 1);
    cfg_write(1'b1, 1, 1'b1, 20'h00400, 22'h30000, 1, 0, 1, 1);
    cfg_write(1'b1, 2, 1'b1, 20'hc0000, 22'h100,   1, 0, 0, 0);
    cfg_write(1'b1, 3, 1'b1, 20'h00500, 22'h7,     0, 0, 0, 1);
    cfg_write(1'b1, 4, 1'b1, 20'h00600, 22'h11,    1, 1, 0, 1);
    cfg_write(1'b1, 5, 1'b1, 20'h00600, 22'h22,    1, 1, 0, 1);

    // Table walk, back-to-back requests.
    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].va, VECS[i].kind, VECS[i].priv);
      chk("R1 rsp_valid", 64'(rsp_valid), 64'd1);
      chk({tag_of(VECS[i].cause), " cause"}, 64'(rsp_cause), 64'(VECS[i].cause));
      chk("R11 fault flag", 64'(rsp_fault), 64'(VECS[i].cause != 2'd0));
      chk({tag_of(VECS[i].cause), " paddr"}, 64'(rsp_paddr), 64'(VECS[i].pa));
    end

    // Idle cycle: no response.
    @(negedge clk); req_valid = 1'b0;
    @(posedge clk); #1;
    chk("R1 idle rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 idle paddr", 64'(rsp_paddr), 64'd0);

    // User-mode rewrite of slot 0 is ignored.
    cfg_write(1'b0, 0, 1'b1, 20'hb7001, 22'h9, 1, 1, 1, 1);
    access(32'hb7001008, 2'd0, 1'b0);
    chk("R10 user write ignored paddr", 64'(rsp_paddr), 64'h2008);
    access(32'hb7001008, 2'd2, 1'b0);
    chk("R10 user write ignored rights", 64'(rsp_cause), 64'd3);
    @(negedge clk); req_valid = 1'b0;

    // Privileged update of slot 1 takes effect.
    cfg_write(1'b1, 1, 1'b1, 20'h00400, 22'h4, 1, 1, 1, 1);
    access(32'h00400010, 2'd1, 1'b0);
    chk("R9 update paddr", 64'(rsp_paddr), 64'h4010);
    chk("R9 update cause", 64'(rsp_cause), 64'd0);

    // Invalidate the lower duplicate, then the upper one.
    cfg_write(1'b1, 4, 1'b0, 20'h00600, 22'h11, 1, 1, 0, 1);
    access(32'h00600044, 2'd0, 1'b0);
    chk("R7 upper duplicate after invalidate", 64'(rsp_paddr), 64'h22044);
    cfg_write(1'b1, 5, 1'b0, 20'h00600, 22'h22, 1, 1, 0, 1);
    access(32'h00600044, 2'd0, 1'b0);
    chk("R9 invalidate gives miss", 64'(rsp_cause), 64'd1);

    // Bypass: kernel page from user, unmapped address, reserved kind.
    @(negedge clk); xlate_en = 1'b0;
    access(32'hc0000123, 2'd1, 1'b0);
    chk("R8 bypass paddr", 64'(rsp_paddr), 64'hc0000123);
    chk("R8 bypass no fault", 64'(rsp_fault), 64'd0);
    access(32'hfffff001, 2'd3, 1'b0);
    chk("R8 bypass unmapped", 64'(rsp_paddr), 64'hfffff001);
    chk("R8 bypass cause", 64'(rsp_cause), 64'd0);
    @(negedge clk); req_valid = 1'b0; xlate_en = 1'b1;

    // Reset clears the table.
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    access(32'hb7001008, 2'd0, 1'b1);
    chk("R3 miss after reset", 64'(rsp_cause), 64'd1);
    chk("R11 miss paddr zero", 64'(rsp_paddr), 64'd0);
    @(negedge clk); req_valid = 1'b0;

    finish_run();
  end

endmodule